// File: doc/BRIEF.md
# Streaming Auto White Balance Gain Controller

The block sits in an RGB pixel stream and corrects colour balance on the fly. Pixels arrive and leave over a valid/ready handshake (AXI4-Stream style). Each beat carries one pixel, with a start-of-frame flag on `tuser` and an end-of-frame flag on `tlast`. Every pixel leaves the block one register stage later, with its red and blue channels scaled by the active gains. Green is always the reference and is passed at unity gain.

In automatic mode a small state machine gathers channel sums over a frame. It leaves out pixels that are clipped bright or crushed dark. Once the frame has ended it divides the green sum by the red and blue sums to get new gains in unsigned Q4.8. The new gains are held pending and become active at the next start of frame, so a frame is never corrected with two different gain sets. An external controller can switch the block to manual mode. In manual mode statistics gathering stops and the controller writes gains directly. The controller can also rewrite both exclusion thresholds at any time.

Top module: `awb_gain_ctrl`

## Requirements
- R1: While `m_tvalid_o` is high and `m_tready_i` is low, the output beat holds steady and `s_tready_o` is low. No input beat is lost or duplicated. After reset `m_tvalid_o` is low and `s_tready_o` is high.
- R2: Pixel fields are R in bits [23:16], G in bits [15:8] and B in bits [7:0]. Each output channel is floor((pixel*gain + 128)/256), saturated to 255, where the gains are Q4.8 with 0x100 = 1.0. Green always uses 0x100. `tuser` and `tlast` pass through with the pixel.
- R3: After reset both active gains are 0x100, the dark threshold is 16 and the bright threshold is 240.
- R4: A pixel is left out of the statistics if any of its channels is at or above the bright threshold, or if all of its channels are at or below the dark threshold.
- R5: In automatic mode a frame is measured from its `tuser` beat through its `tlast` beat. The R gain becomes floor(sumG*256/sumR) and the B gain becomes floor(sumG*256/sumB), each clamped to 0xFFF.
- R6: A computed or written gain takes effect from the first pixel of the next frame that starts with `tuser`. Pixels already inside a frame keep the gains that frame started with.
- R7: If no pixel of a frame was included, or if any channel sum is zero, the previous gains are kept.
- R8: While `manual_i` is high, automatic computation is suspended. Gains written with `gain_we_i` are latched and then follow R6.
- R9: A pulse on `thr_we_i` loads both thresholds. The new thresholds apply to every later pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| s_tdata_i | input | 24 | Input pixel {R,G,B} |
| s_tvalid_i | input | 1 | Input beat valid |
| s_tuser_i | input | 1 | Input start of frame |
| s_tlast_i | input | 1 | Input last pixel of frame |
| s_tready_o | output | 1 | Block can take an input beat |
| m_tdata_o | output | 24 | Corrected pixel {R,G,B} |
| m_tvalid_o | output | 1 | Output beat valid |
| m_tuser_o | output | 1 | Output start of frame |
| m_tlast_o | output | 1 | Output last pixel of frame |
| m_tready_i | input | 1 | Downstream takes the output beat |
| manual_i | input | 1 | 1 = manual gains, 0 = automatic |
| gain_we_i | input | 1 | Write strobe for gains |
| gain_r_i | input | 12 | Red gain to write, Q4.8 |
| gain_b_i | input | 12 | Blue gain to write, Q4.8 |
| thr_we_i | input | 1 | Write strobe for thresholds |
| thr_lo_i | input | 8 | Dark threshold to write |
| thr_hi_i | input | 8 | Bright threshold to write |

## Verification
An error in the channel sums or in the divider is invisible during the frame being measured. It appears only as wrong R and B values on the first pixel of the next frame that starts after the update, roughly 45 cycles after `tlast`. Each measured frame is therefore followed by a frame of known pixels whose expected output is worked out from the sums of the included pixels alone. An error in the exclusion rule, the zero-sum guard or the mode logic shows up the same way. In each of these cases the gains differ from the ones that a correct inclusion set, kept gains or manual writes would give. A fault in the output stage or in the gain latch shows on the very next output beat.

// File: rtl/awb_pkg.sv
package awb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_ACCUM   = 2'd1,
    ST_COMPUTE = 2'd2,
    ST_UPDATE  = 2'd3
  } awb_state_e;

  localparam int CH_R = 0;
  localparam int CH_B = 1;
endpackage

// File: rtl/awb_stats.sv
module awb_stats #(
  parameter int PIX_W = 8,
  parameter int SUM_W = 30,
  parameter int CNT_W = 23
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic               add_i,
  input  logic [3*PIX_W-1:0] pix_i,
  input  logic [PIX_W-1:0]   thr_lo_i,
  input  logic [PIX_W-1:0]   thr_hi_i,
  output logic [SUM_W-1:0]   sum_r_o,
  output logic [SUM_W-1:0]   sum_g_o,
  output logic [SUM_W-1:0]   sum_b_o,
  output logic [CNT_W-1:0]   cnt_o
);
  logic [PIX_W-1:0] r, g, b;
  logic hot, dark, excl;

  assign r = pix_i[3*PIX_W-1:2*PIX_W];
  assign g = pix_i[2*PIX_W-1:PIX_W];
  assign b = pix_i[PIX_W-1:0];

  assign hot  = (r >= thr_hi_i) | (g >= thr_hi_i) | (b >= thr_hi_i);
  assign dark = (r <= thr_lo_i) & (g <= thr_lo_i) & (b <= thr_lo_i);
  assign excl = hot | dark;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_r_o <= '0;
      sum_g_o <= '0;
      sum_b_o <= '0;
      cnt_o   <= '0;
    end else if (load_i) begin
      sum_r_o <= excl ? '0 : SUM_W'(r);
      sum_g_o <= excl ? '0 : SUM_W'(g);
      sum_b_o <= excl ? '0 : SUM_W'(b);
      cnt_o   <= excl ? '0 : CNT_W'(1);
    end else if (add_i && !excl) begin
      sum_r_o <= sum_r_o + SUM_W'(r);
      sum_g_o <= sum_g_o + SUM_W'(g);
      sum_b_o <= sum_b_o + SUM_W'(b);
      cnt_o   <= cnt_o + CNT_W'(1);
    end
  end

  // R4: an excluded pixel leaves the statistics untouched
  a_r4_excluded_no_effect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (add_i && !load_i && excl) |=> ($stable(sum_r_o) && $stable(sum_g_o) &&
                                    $stable(sum_b_o) && $stable(cnt_o)));
endmodule

// File: rtl/awb_div.sv
module awb_div #(
  parameter int NUM_W = 38,
  parameter int DEN_W = 30
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [NUM_W-1:0] quot_o
);
  localparam int CNT_W  = $clog2(NUM_W + 1);
  localparam int CHK_W  = NUM_W + DEN_W;

  logic [NUM_W-1:0] shreg_q, num_q;
  logic [DEN_W-1:0] rem_q, den_q;
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q, done_q;
  logic [DEN_W:0]   trial;
  logic             fits;

  assign trial = {rem_q, shreg_q[NUM_W-1]};
  assign fits  = trial >= {1'b0, den_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q <= '0;
      num_q   <= '0;
      rem_q   <= '0;
      den_q   <= '0;
      cnt_q   <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !busy_q) begin
        shreg_q <= num_i;
        num_q   <= num_i;
        den_q   <= den_i;
        rem_q   <= '0;
        cnt_q   <= CNT_W'(NUM_W);
        busy_q  <= 1'b1;
      end else if (busy_q) begin
        rem_q   <= fits ? DEN_W'(trial - {1'b0, den_q}) : trial[DEN_W-1:0];
        shreg_q <= {shreg_q[NUM_W-2:0], fits};
        cnt_q   <= cnt_q - CNT_W'(1);
        if (cnt_q == CNT_W'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign quot_o = shreg_q;

  logic [CHK_W-1:0] recon;
  assign recon = CHK_W'(shreg_q) * CHK_W'(den_q) + CHK_W'(rem_q);

  // R5: quotient and remainder reconstruct the captured numerator
  a_r5_div_exact: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (recon == CHK_W'(num_q)) && (rem_q < den_q));
endmodule

// File: rtl/awb_apply.sv
module awb_apply #(
  parameter int PIX_W  = 8,
  parameter int GAIN_W = 12,
  parameter int FRAC_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [3*PIX_W-1:0] s_tdata_i,
  input  logic               s_tvalid_i,
  input  logic               s_tuser_i,
  input  logic               s_tlast_i,
  output logic               s_tready_o,
  input  logic [GAIN_W-1:0]  gain_r_i,
  input  logic [GAIN_W-1:0]  gain_b_i,
  output logic [3*PIX_W-1:0] m_tdata_o,
  output logic               m_tvalid_o,
  output logic               m_tuser_o,
  output logic               m_tlast_o,
  input  logic               m_tready_i
);
  localparam int PROD_W = PIX_W + GAIN_W + 1;
  localparam int HALF   = 1 << (FRAC_W - 1);
  localparam int UNITY  = 1 << FRAC_W;

  function automatic logic [PIX_W-1:0] scale(input logic [PIX_W-1:0] p,
                                             input logic [GAIN_W-1:0] g);
    logic [PROD_W-1:0] prod;
    prod = PROD_W'(p) * PROD_W'(g) + PROD_W'(HALF);
    prod = prod >> FRAC_W;
    return (|prod[PROD_W-1:PIX_W]) ? {PIX_W{1'b1}} : prod[PIX_W-1:0];
  endfunction

  logic [GAIN_W-1:0]  g_ch [3];
  logic [3*PIX_W-1:0] scaled;
  logic               load;

  assign g_ch[0] = gain_b_i;
  assign g_ch[1] = GAIN_W'(UNITY);
  assign g_ch[2] = gain_r_i;

  for (genvar ch = 0; ch < 3; ch++) begin : g_chan
    assign scaled[ch*PIX_W +: PIX_W] = scale(s_tdata_i[ch*PIX_W +: PIX_W], g_ch[ch]);
  end

  assign s_tready_o = !m_tvalid_o || m_tready_i;
  assign load       = s_tvalid_i && s_tready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_tvalid_o <= 1'b0;
      m_tdata_o  <= '0;
      m_tuser_o  <= 1'b0;
      m_tlast_o  <= 1'b0;
    end else if (s_tready_o) begin
      m_tvalid_o <= s_tvalid_i;
      if (load) begin
        m_tdata_o <= scaled;
        m_tuser_o <= s_tuser_i;
        m_tlast_o <= s_tlast_i;
      end
    end
  end

  a_r1_stall_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_tvalid_o && !m_tready_i) |=> (m_tvalid_o && $stable(m_tdata_o) &&
                                     $stable(m_tuser_o) && $stable(m_tlast_o)));

  a_r2_green_unity: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |=> (m_tdata_o[2*PIX_W-1:PIX_W] == $past(s_tdata_i[2*PIX_W-1:PIX_W])));
endmodule

// File: rtl/awb_gain_ctrl.sv
module awb_gain_ctrl #(
  parameter int PIX_W      = 8,
  parameter int INT_W      = 4,
  parameter int FRAC_W     = 8,
  parameter int FRAME_LOG2 = 22,
  parameter int THR_LO_RST = 16,
  parameter int THR_HI_RST = 240
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [3*PIX_W-1:0]        s_tdata_i,
  input  logic                      s_tvalid_i,
  input  logic                      s_tuser_i,
  input  logic                      s_tlast_i,
  output logic                      s_tready_o,
  output logic [3*PIX_W-1:0]        m_tdata_o,
  output logic                      m_tvalid_o,
  output logic                      m_tuser_o,
  output logic                      m_tlast_o,
  input  logic                      m_tready_i,
  input  logic                      manual_i,
  input  logic                      gain_we_i,
  input  logic [INT_W+FRAC_W-1:0]   gain_r_i,
  input  logic [INT_W+FRAC_W-1:0]   gain_b_i,
  input  logic                      thr_we_i,
  input  logic [PIX_W-1:0]          thr_lo_i,
  input  logic [PIX_W-1:0]          thr_hi_i
);
  import awb_pkg::*;

  localparam int GAIN_W   = INT_W + FRAC_W;
  localparam int SUM_W    = PIX_W + FRAME_LOG2;
  localparam int CNT_W    = FRAME_LOG2 + 1;
  localparam int NUM_W    = SUM_W + FRAC_W;
  localparam int GAIN_MAX = (1 << GAIN_W) - 1;
  localparam int UNITY    = 1 << FRAC_W;

  awb_state_e        st_q;
  logic              launched_q;
  logic [PIX_W-1:0]  thr_lo_q, thr_hi_q;
  logic [GAIN_W-1:0] pend_r_q, pend_b_q, act_r_q, act_b_q;
  logic [GAIN_W-1:0] use_r, use_b;
  logic [SUM_W-1:0]  sum_r, sum_g, sum_b;
  logic [CNT_W-1:0]  cnt;
  logic              accept, sof, eof, stats_load, stats_add, sums_ok, div_start;
  logic [SUM_W-1:0]  den   [2];
  logic [NUM_W-1:0]  quot  [2];
  logic [GAIN_W-1:0] g_new [2];
  logic [1:0]        div_busy, div_done;

  assign accept = s_tvalid_i && s_tready_o;
  assign sof    = accept && s_tuser_i;
  assign eof    = accept && s_tlast_i;

  assign stats_load = sof && !manual_i && (st_q == ST_IDLE || st_q == ST_ACCUM);
  assign stats_add  = accept && !manual_i && st_q == ST_ACCUM;

  awb_stats #(.PIX_W(PIX_W), .SUM_W(SUM_W), .CNT_W(CNT_W)) u_stats (
    .clk_i, .rst_ni,
    .load_i(stats_load), .add_i(stats_add), .pix_i(s_tdata_i),
    .thr_lo_i(thr_lo_q), .thr_hi_i(thr_hi_q),
    .sum_r_o(sum_r), .sum_g_o(sum_g), .sum_b_o(sum_b), .cnt_o(cnt)
  );

  assign sums_ok   = (cnt != '0) && (sum_r != '0) && (sum_g != '0) && (sum_b != '0);
  assign div_start = st_q == ST_COMPUTE && !launched_q && !manual_i && sums_ok && !(|div_busy);
  assign den[CH_R] = sum_r;
  assign den[CH_B] = sum_b;

  for (genvar i = 0; i < 2; i++) begin : g_div
    awb_div #(.NUM_W(NUM_W), .DEN_W(SUM_W)) u_div (
      .clk_i, .rst_ni,
      .start_i(div_start), .num_i({sum_g, {FRAC_W{1'b0}}}), .den_i(den[i]),
      .busy_o(div_busy[i]), .done_o(div_done[i]), .quot_o(quot[i])
    );
    assign g_new[i] = (quot[i] > NUM_W'(GAIN_MAX)) ? GAIN_W'(GAIN_MAX) : quot[i][GAIN_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      launched_q <= 1'b0;
    end else begin
      launched_q <= (st_q == ST_COMPUTE) && (launched_q || div_start);
      if (manual_i) st_q <= ST_IDLE;
      else begin
        unique case (st_q)
          ST_IDLE:    if (sof) st_q <= eof ? ST_COMPUTE : ST_ACCUM;
          ST_ACCUM:   if (eof) st_q <= ST_COMPUTE;
          ST_COMPUTE: begin
            if (!launched_q && !sums_ok) st_q <= ST_IDLE;
            else if (launched_q && div_done[0]) st_q <= ST_UPDATE;
          end
          ST_UPDATE:  st_q <= ST_IDLE;
          default:    st_q <= ST_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_r_q <= GAIN_W'(UNITY);
      pend_b_q <= GAIN_W'(UNITY);
      act_r_q  <= GAIN_W'(UNITY);
      act_b_q  <= GAIN_W'(UNITY);
      thr_lo_q <= PIX_W'(THR_LO_RST);
      thr_hi_q <= PIX_W'(THR_HI_RST);
    end else begin
      if (gain_we_i) begin
        pend_r_q <= gain_r_i;
        pend_b_q <= gain_b_i;
      end else if (st_q == ST_UPDATE && !manual_i) begin
        pend_r_q <= g_new[CH_R];
        pend_b_q <= g_new[CH_B];
      end
      if (sof) begin
        act_r_q <= pend_r_q;
        act_b_q <= pend_b_q;
      end
      if (thr_we_i) begin
        thr_lo_q <= thr_lo_i;
        thr_hi_q <= thr_hi_i;
      end
    end
  end

  // first pixel of a frame already uses the pending gains
  assign use_r = sof ? pend_r_q : act_r_q;
  assign use_b = sof ? pend_b_q : act_b_q;

  awb_apply #(.PIX_W(PIX_W), .GAIN_W(GAIN_W), .FRAC_W(FRAC_W)) u_apply (
    .clk_i, .rst_ni,
    .s_tdata_i, .s_tvalid_i, .s_tuser_i, .s_tlast_i, .s_tready_o,
    .gain_r_i(use_r), .gain_b_i(use_b),
    .m_tdata_o, .m_tvalid_o, .m_tuser_o, .m_tlast_o, .m_tready_i
  );

  a_r8_manual_suspends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    manual_i |=> st_q == ST_IDLE);

  a_r6_active_only_at_sof: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sof |=> ($stable(act_r_q) && $stable(act_b_q)));

  a_r7_pending_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_UPDATE && !gain_we_i) |=> ($stable(pend_r_q) && $stable(pend_b_q)));

  a_r9_thr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !thr_we_i |=> ($stable(thr_lo_q) && $stable(thr_hi_q)));
endmodule

// File: tb/sim_awb_gain_ctrl.sv
module sim_awb_gain_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [23:0] s_tdata_i = '0;
  logic        s_tvalid_i = 1'b0, s_tuser_i = 1'b0, s_tlast_i = 1'b0;
  logic        s_tready_o;
  logic [23:0] m_tdata_o;
  logic        m_tvalid_o, m_tuser_o, m_tlast_o;
  logic        m_tready_i = 1'b1;
  logic        manual_i = 1'b1, gain_we_i = 1'b0, thr_we_i = 1'b0;
  logic [11:0] gain_r_i = '0, gain_b_i = '0;
  logic [7:0]  thr_lo_i = '0, thr_hi_i = '0;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk_i = ~clk_i;

  awb_gain_ctrl u0 (.*);

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  // drive one pixel, wait for accept, check the registered output
  task automatic px(input logic [7:0] r, g, b, input bit sof, last,
                    input logic [7:0] er, eg, eb, input string tag);
    @(negedge clk_i);
    s_tdata_i = {r, g, b}; s_tuser_i = sof; s_tlast_i = last; s_tvalid_i = 1'b1;
    while (!s_tready_o) @(negedge clk_i);
    @(negedge clk_i);
    s_tvalid_i = 1'b0; s_tuser_i = 1'b0; s_tlast_i = 1'b0;
    check(m_tvalid_o && m_tdata_o == {er, eg, eb} && m_tuser_o == sof && m_tlast_o == last,
          tag, {5'd0, m_tvalid_o, m_tuser_o, m_tlast_o, m_tdata_o},
          {5'd0, 1'b1, sof, last, er, eg, eb});
  endtask

  task automatic write_gain(input logic [11:0] gr, gb);
    @(negedge clk_i);
    gain_we_i = 1'b1; gain_r_i = gr; gain_b_i = gb;
    @(negedge clk_i);
    gain_we_i = 1'b0;
  endtask

  task automatic t_reset;
    check(!m_tvalid_o && s_tready_o, "R1 reset handshake", {m_tvalid_o, s_tready_o}, 32'h1);
    px(100, 50, 200, 1, 1, 100, 50, 200, "R3 unity gains after reset");
  endtask

  task automatic t_auto;
    @(negedge clk_i); manual_i = 1'b0;
    px(64, 128, 32, 1, 0, 64, 128, 32, "R5 measured frame px0");
    px(64, 128, 32, 0, 0, 64, 128, 32, "R6 old gains mid frame");
    px(64, 128, 32, 0, 0, 64, 128, 32, "R5 measured frame px2");
    px(64, 128, 32, 0, 1, 64, 128, 32, "R5 measured frame last");
    idle(80);
    px(64, 128, 32, 1, 1, 128, 128, 128, "R5 gains 2.0/4.0 applied");
    idle(80);
  endtask

  task automatic t_exclude;
    px(40, 120, 60, 1, 0, 80, 120, 240, "R2 scaled pixel");
    px(240, 100, 100, 0, 0, 255, 100, 255, "R2 saturation");
    px(16, 16, 16, 0, 0, 32, 16, 64, "R2 dark pixel scaled");
    px(40, 120, 60, 0, 1, 80, 120, 240, "R2 last pixel");
    idle(80);
    px(40, 120, 60, 1, 1, 120, 120, 120, "R4 bright and dark boundary pixels excluded");
    idle(80);
  endtask

  task automatic t_keep;
    px(5, 5, 5, 1, 0, 15, 5, 10, "R2 rounding down");
    px(250, 0, 0, 0, 1, 255, 0, 0, "R2 saturate red");
    idle(80);
    px(40, 120, 60, 1, 1, 120, 120, 120, "R7 empty frame keeps gains");
    idle(80);
    px(50, 60, 0, 1, 1, 150, 60, 0, "R2 zero blue");
    idle(80);
    px(40, 120, 60, 1, 1, 120, 120, 120, "R7 zero blue sum keeps gains");
    idle(80);
  endtask

  task automatic t_gain_clamp;
    px(1, 200, 20, 1, 1, 3, 200, 40, "R2 small pixel");
    idle(80);
    px(1, 200, 20, 1, 1, 16, 200, 200, "R5 gain clamped to 0xFFF");
    idle(80);
  endtask

  task automatic t_thresh;
    @(negedge clk_i);
    thr_we_i = 1'b1; thr_lo_i = 8'd50; thr_hi_i = 8'd200;
    @(negedge clk_i);
    thr_we_i = 1'b0;
    px(45, 45, 45, 1, 0, 255, 45, 255, "R2 clamp both");
    px(210, 100, 100, 0, 0, 255, 100, 255, "R2 clamp both b");
    px(100, 100, 50, 0, 1, 255, 100, 255, "R2 clamp both c");
    idle(80);
    px(100, 100, 50, 1, 1, 100, 100, 100, "R9 new thresholds exclude pixels");
    idle(80);
  endtask

  task automatic t_manual;
    @(negedge clk_i); manual_i = 1'b1;
    write_gain(12'h180, 12'h080);
    px(3, 7, 3, 1, 0, 5, 7, 2, "R8 written gains with rounding");
    write_gain(12'h200, 12'h100);
    px(3, 7, 3, 0, 1, 5, 7, 2, "R6 mid-frame write deferred");
    px(3, 7, 3, 1, 1, 6, 7, 3, "R8 second write applied");
    px(64, 128, 32, 1, 1, 128, 128, 32, "R8 manual frame");
    idle(80);
    px(64, 128, 32, 1, 1, 128, 128, 32, "R8 automatic computation suspended");
  endtask

  task automatic t_backpressure;
    @(negedge clk_i);
    m_tready_i = 1'b0;
    s_tdata_i = {8'd10, 8'd20, 8'd30}; s_tuser_i = 1'b1; s_tlast_i = 1'b0; s_tvalid_i = 1'b1;
    @(negedge clk_i);
    s_tdata_i = {8'd50, 8'd60, 8'd70}; s_tuser_i = 1'b0; s_tlast_i = 1'b1;
    for (int i = 0; i < 3; i++) begin
      check(!s_tready_o && m_tvalid_o && m_tdata_o == {8'd20, 8'd20, 8'd30},
            "R1 stalled beat held", {7'd0, s_tready_o, m_tdata_o}, {8'd0, 8'd20, 8'd20, 8'd30});
      @(negedge clk_i);
    end
    m_tready_i = 1'b1;
    @(negedge clk_i);
    s_tvalid_i = 1'b0; s_tlast_i = 1'b0;
    check(m_tvalid_o && m_tlast_o && m_tdata_o == {8'd100, 8'd60, 8'd70},
          "R1 next beat after release", {7'd0, m_tlast_o, m_tdata_o}, {8'd1, 8'd100, 8'd60, 8'd70});
    @(negedge clk_i);
    check(!m_tvalid_o, "R1 no duplicate beat", {31'd0, m_tvalid_o}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_auto();
    t_exclude();
    t_keep();
    t_gain_clamp();
    t_thresh();
    t_manual();
    t_backpressure();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule